// File: doc/BRIEF.md
# Ethernet controller control/status register bank

This block is the register interface that host software uses to control a 10 Mb/s Ethernet controller. Access is indirect: the host first writes a register number into an address port, then reads or writes the chosen register through a single 16-bit data port. Four registers are reachable this way. The run register holds the run-control commands (initialise, start, stop, transmit poll), seven sticky event flags, a derived error summary, the interrupt request and the interrupt enable. The next two registers hold a 24-bit pointer to the initialisation block in memory. The last holds three bus configuration bits.

The MAC and DMA engines report events to the block as single-cycle pulses. The block gives them back level outputs: an initialisation request, receiver and transmitter enables, a one-cycle transmit poll strobe, the initialisation block pointer and the bus configuration. It also drives an active-low interrupt line. A stop command returns the run register to its idle state. Initialise and start then bring the controller up in order, and completion of initialisation is reported through a done flag.

Top module: `eth_csr_bank`

## Requirements
- R1: A write with `host_port`=1 loads `host_wdata[1:0]` into the register select (0 run, 1 pointer low, 2 pointer high, 3 bus config). With `host_port`=1, `host_rdata` returns the select value zero-extended. With `host_port`=0, reads and writes go to the selected register.
- R2: After reset the run register reads 0x0004 (stopped) and the other three registers read zero. `irq_n` is high and `rx_on`, `tx_on`, `tx_poll` and `init_req` are low.
- R3: Run register layout: bit 15 error summary, 14 babble, 13 heartbeat error, 12 missed frame, 11 memory error, 10 receive done, 9 transmit done, 8 init done, 7 interrupt request, 6 interrupt enable, 5 receiver on, 4 transmitter on, 3 transmit poll, 2 stop, 1 start, 0 init.
- R4: Bit 15 always reads as the OR of bits 14, 13, 12 and 11. Writing bit 15 has no effect.
- R5: Writing a one to any of bits 14 to 8 clears that flag, and writing a zero leaves it unchanged. If an event pulse arrives in the same cycle as the clearing write, the flag stays set.
- R6: An event pulse sets its flag at the next clock edge, but only while the stop bit is clear. While stopped, all flags read zero.
- R7: Bit 7 is the OR of bits 14, 12, 11, 10, 9 and 8. The heartbeat error flag is not included. `irq_n` is low exactly when bit 7 and bit 6 are both set.
- R8: A run register write with bit 2 set takes priority over every other bit of that write. It sets stop and clears init, start, receiver on, transmitter on, transmit poll, interrupt enable, the init-complete state and all flags. It leaves the pointer and bus configuration registers unchanged.
- R9: A run register write with bit 0 or bit 1 set (and bit 2 clear) clears stop. Bit 0 sets init, which drives `init_req`. An `ev_init_done` pulse while init is set clears init and sets the init done flag. When init is clear the pulse is ignored.
- R10: Receiver on and transmitter on become set once start is set and initialisation has completed since the last stop, in either order. Both stay set until the next stop.
- R11: A run register write with bit 3 set, when the write leaves the block not stopped, raises transmit poll (`tx_poll`) for exactly one cycle. While stopped the request is dropped.
- R12: The pointer low (16 bits), pointer high (8 bits, upper bits read zero) and bus config (3 bits, upper bits read zero) registers accept writes only while stopped. `init_addr` is {high, low} and `bus_cfg` follows the bus config register.
- R13: Every run register write without bit 2 loads the interrupt enable from bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_port | input | 1 | 1 = address port, 0 = data port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed port |
| ev_babble | input | 1 | Transmit babble event pulse |
| ev_sqe | input | 1 | Heartbeat (collision test) error pulse |
| ev_missed | input | 1 | Missed frame pulse |
| ev_memerr | input | 1 | Memory error pulse |
| ev_rx_done | input | 1 | Receive completed pulse |
| ev_tx_done | input | 1 | Transmit completed pulse |
| ev_init_done | input | 1 | Initialisation block read completed pulse |
| init_req | output | 1 | Initialisation requested |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |
| tx_poll | output | 1 | One-cycle transmit descriptor poll strobe |
| irq_n | output | 1 | Active-low interrupt |
| init_addr | output | 24 | Initialisation block pointer |
| bus_cfg | output | 3 | Bus configuration bits |

## Verification
The bench builds the block with the default 24-bit pointer and 3-bit bus configuration. This makes the high pointer register 8 bits wide, so a write of all ones exposes both the stored byte and the zero-filled upper byte on readback. With the defaults, the lock on configuration writes, the priority of stop over every other command, and the event-versus-clear collision are all reached by directed sequences. A long random phase with rare stop commands then mixes restarts, polls and bursts of events, and a behavioural model checks every cycle.

// File: rtl/eth_csr_pkg.sv
package eth_csr_pkg;
  localparam int CSR_W   = 16;
  localparam int NFLAG   = 7;
  // run register bit positions
  localparam int B_INIT  = 0;
  localparam int B_STRT  = 1;
  localparam int B_STOP  = 2;
  localparam int B_POLL  = 3;
  localparam int B_INEA  = 6;
  localparam int B_FLAG0 = 8;
  localparam int B_ERR   = 15;
  // flag vector positions (bit k maps to run register bit B_FLAG0+k)
  localparam int F_IDON  = 0;
  localparam int F_TINT  = 1;
  localparam int F_RINT  = 2;
  localparam int F_MERR  = 3;
  localparam int F_MISS  = 4;
  localparam int F_CERR  = 5;
  localparam int F_BABL  = 6;

  typedef enum logic [1:0] {
    SEL_RUN  = 2'd0,
    SEL_IBLO = 2'd1,
    SEL_IBHI = 2'd2,
    SEL_BUS  = 2'd3
  } csr_sel_e;
endpackage

// File: rtl/csr_event_flags.sv
module csr_event_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stopped_i,
  input  logic         stop_wr_i,
  input  logic [N-1:0] w1c_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] flags_q, flags_d;
  logic [N-1:0] set_gated;

  always_comb begin
    set_gated = stopped_i ? '0 : set_i;
    if (stop_wr_i) flags_d = '0;
    else           flags_d = (flags_q & ~w1c_i) | set_gated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  // R6: no flag survives while the controller is stopped
  a_r6_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped_i |-> (flags_q == '0));

  // R5: an accepted event is visible after the edge even against a clear
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((|set_i) && !stopped_i && !stop_wr_i) |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/csr_run_ctrl.sv
module csr_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic cmd_init_i,
  input  logic cmd_strt_i,
  input  logic cmd_stop_i,
  input  logic cmd_poll_i,
  input  logic cmd_inea_i,
  input  logic init_done_i,
  output logic init_o,
  output logic strt_o,
  output logic stop_o,
  output logic poll_o,
  output logic rxon_o,
  output logic txon_o,
  output logic inea_o,
  output logic init_fin_o
);
  logic init_q, strt_q, stop_q, poll_q, rxon_q, txon_q, inea_q, ready_q;
  logic init_d, strt_d, stop_d, poll_d, rxon_d, txon_d, inea_d, ready_d;
  logic fin;

  assign fin = init_done_i & init_q;

  always_comb begin
    init_d  = init_q;
    strt_d  = strt_q;
    stop_d  = stop_q;
    poll_d  = 1'b0;
    rxon_d  = rxon_q;
    txon_d  = txon_q;
    inea_d  = inea_q;
    ready_d = ready_q;
    if (wr_i && cmd_stop_i) begin
      init_d  = 1'b0;
      strt_d  = 1'b0;
      stop_d  = 1'b1;
      rxon_d  = 1'b0;
      txon_d  = 1'b0;
      inea_d  = 1'b0;
      ready_d = 1'b0;
    end else begin
      if (wr_i && cmd_init_i) init_d = 1'b1;
      else if (fin)           init_d = 1'b0;
      ready_d = ready_q | fin;
      strt_d  = strt_q | (wr_i & cmd_strt_i);
      stop_d  = stop_q & ~(wr_i & (cmd_init_i | cmd_strt_i));
      if (wr_i) inea_d = cmd_inea_i;
      poll_d  = wr_i & cmd_poll_i & ~stop_d;
      rxon_d  = rxon_q | (strt_d & ready_d);
      txon_d  = txon_q | (strt_d & ready_d);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q  <= 1'b0;
      strt_q  <= 1'b0;
      stop_q  <= 1'b1;
      poll_q  <= 1'b0;
      rxon_q  <= 1'b0;
      txon_q  <= 1'b0;
      inea_q  <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      init_q  <= init_d;
      strt_q  <= strt_d;
      stop_q  <= stop_d;
      poll_q  <= poll_d;
      rxon_q  <= rxon_d;
      txon_q  <= txon_d;
      inea_q  <= inea_d;
      ready_q <= ready_d;
    end
  end

  assign init_o     = init_q;
  assign strt_o     = strt_q;
  assign stop_o     = stop_q;
  assign poll_o     = poll_q;
  assign rxon_o     = rxon_q;
  assign txon_o     = txon_q;
  assign inea_o     = inea_q;
  assign init_fin_o = fin;

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && cmd_stop_i) |=> (stop_q && !init_q && !strt_q && !rxon_q && !txon_q && !poll_q && !inea_q));

  a_r11_poll_single: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_q && !wr_i) |=> !poll_q);

  a_r11_poll_not_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    poll_q |-> !stop_q);

  a_r10_on_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (rxon_q || txon_q) |-> strt_q);

  a_r9_start_leaves_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !cmd_stop_i && (cmd_init_i || cmd_strt_i)) |=> !stop_q);
endmodule

// File: rtl/csr_cfg_regs.sv
module csr_cfg_regs import eth_csr_pkg::*; #(
  parameter int HI_W  = 8,
  parameter int BUS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             stopped_i,
  input  csr_sel_e         sel_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] lo_o,
  output logic [HI_W-1:0]  hi_o,
  output logic [BUS_W-1:0] bus_o
);
  logic [CSR_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [BUS_W-1:0] bus_q, bus_d;
  logic             wr_ok;

  assign wr_ok = we_i & stopped_i;

  always_comb begin
    lo_d  = lo_q;
    hi_d  = hi_q;
    bus_d = bus_q;
    if (wr_ok) begin
      case (sel_i)
        SEL_IBLO: lo_d  = wdata_i;
        SEL_IBHI: hi_d  = wdata_i[HI_W-1:0];
        SEL_BUS:  bus_d = wdata_i[BUS_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      bus_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      bus_q <= bus_d;
    end
  end

  assign lo_o  = lo_q;
  assign hi_o  = hi_q;
  assign bus_o = bus_q;

  // R12: configuration is frozen while the controller runs
  a_r12_locked_when_running: assert property (@(posedge clk) disable iff (!rst_n)
    !stopped_i |=> $stable({lo_q, hi_q, bus_q}));
endmodule

// File: rtl/eth_csr_bank.sv
module eth_csr_bank import eth_csr_pkg::*; #(
  parameter int IBA_W = 24,
  parameter int BUS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic             host_port,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  input  logic             ev_babble,
  input  logic             ev_sqe,
  input  logic             ev_missed,
  input  logic             ev_memerr,
  input  logic             ev_rx_done,
  input  logic             ev_tx_done,
  input  logic             ev_init_done,
  output logic             init_req,
  output logic             rx_on,
  output logic             tx_on,
  output logic             tx_poll,
  output logic             irq_n,
  output logic [IBA_W-1:0] init_addr,
  output logic [BUS_W-1:0] bus_cfg
);
  localparam int HI_W = IBA_W - CSR_W;

  csr_sel_e         sel_q, sel_d;
  logic             data_wr, run_wr;
  logic [NFLAG-1:0] flags, w1c, ev_set;
  logic             init_b, strt_b, stop_b, poll_b, rxon_b, txon_b, inea_b, init_fin;
  logic             err_sum, intr;
  logic [CSR_W-1:0] run_word, lo_w;
  logic [HI_W-1:0]  hi_w;
  logic [BUS_W-1:0] bus_w;

  // address port
  always_comb begin
    sel_d = sel_q;
    if (host_we && host_port) sel_d = csr_sel_e'(host_wdata[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_RUN;
    else        sel_q <= sel_d;
  end

  assign data_wr = host_we & ~host_port;
  assign run_wr  = data_wr & (sel_q == SEL_RUN);
  assign w1c     = run_wr ? host_wdata[B_FLAG0 +: NFLAG] : '0;
  assign ev_set  = {ev_babble, ev_sqe, ev_missed, ev_memerr, ev_rx_done, ev_tx_done, init_fin};

  csr_run_ctrl u_run (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (run_wr),
    .cmd_init_i  (host_wdata[B_INIT]),
    .cmd_strt_i  (host_wdata[B_STRT]),
    .cmd_stop_i  (host_wdata[B_STOP]),
    .cmd_poll_i  (host_wdata[B_POLL]),
    .cmd_inea_i  (host_wdata[B_INEA]),
    .init_done_i (ev_init_done),
    .init_o      (init_b),
    .strt_o      (strt_b),
    .stop_o      (stop_b),
    .poll_o      (poll_b),
    .rxon_o      (rxon_b),
    .txon_o      (txon_b),
    .inea_o      (inea_b),
    .init_fin_o  (init_fin)
  );

  csr_event_flags #(.N(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .stopped_i (stop_b),
    .stop_wr_i (run_wr & host_wdata[B_STOP]),
    .w1c_i     (w1c),
    .set_i     (ev_set),
    .flags_o   (flags)
  );

  csr_cfg_regs #(.HI_W(HI_W), .BUS_W(BUS_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (data_wr),
    .stopped_i (stop_b),
    .sel_i     (sel_q),
    .wdata_i   (host_wdata),
    .lo_o      (lo_w),
    .hi_o      (hi_w),
    .bus_o     (bus_w)
  );

  assign err_sum  = flags[F_BABL] | flags[F_CERR] | flags[F_MISS] | flags[F_MERR];
  assign intr     = flags[F_BABL] | flags[F_MISS] | flags[F_MERR] |
                    flags[F_RINT] | flags[F_TINT] | flags[F_IDON];
  assign run_word = {err_sum, flags, intr, inea_b, rxon_b, txon_b, poll_b, stop_b, strt_b, init_b};

  always_comb begin
    if (host_port) host_rdata = {{(CSR_W-2){1'b0}}, sel_q};
    else begin
      case (sel_q)
        SEL_RUN:  host_rdata = run_word;
        SEL_IBLO: host_rdata = lo_w;
        SEL_IBHI: host_rdata = {{(CSR_W-HI_W){1'b0}}, hi_w};
        default:  host_rdata = {{(CSR_W-BUS_W){1'b0}}, bus_w};
      endcase
    end
  end

  assign irq_n     = ~(intr & inea_b);
  assign init_req  = init_b;
  assign rx_on     = rxon_b;
  assign tx_on     = txon_b;
  assign tx_poll   = poll_b;
  assign init_addr = {hi_w, lo_w};
  assign bus_cfg   = bus_w;

  a_r4_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_port && sel_q == SEL_RUN) |-> (host_rdata[15] == (|host_rdata[14:11])));

  a_r7_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (inea_b && (|(flags & ~(NFLAG'(1) << F_CERR)))));

  a_r1_addr_readback: assert property (@(posedge clk) disable iff (!rst_n)
    host_port |-> (host_rdata[15:2] == '0));
endmodule

// File: tb/test_eth_csr_bank.sv
module test_eth_csr_bank;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        host_we, host_port;
  logic [15:0] host_wdata, host_rdata;
  logic [6:0]  ev;
  logic        init_req, rx_on, tx_on, tx_poll, irq_n;
  logic [23:0] init_addr;
  logic [2:0]  bus_cfg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  eth_csr_bank i_eth_csr_bank (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_port(host_port),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_babble(ev[6]), .ev_sqe(ev[5]), .ev_missed(ev[4]), .ev_memerr(ev[3]),
    .ev_rx_done(ev[2]), .ev_tx_done(ev[1]), .ev_init_done(ev[0]),
    .init_req(init_req), .rx_on(rx_on), .tx_on(tx_on), .tx_poll(tx_poll),
    .irq_n(irq_n), .init_addr(init_addr), .bus_cfg(bus_cfg)
  );

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  // behavioural reference state
  logic [1:0]  m_sel;
  logic [6:0]  m_fl;
  logic        m_init, m_strt, m_stop, m_poll, m_rxon, m_txon, m_inea, m_ok;
  logic [15:0] m_lo;
  logic [7:0]  m_hi;
  logic [2:0]  m_bus;
  logic        t_w0, t_fin, t_go;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_fl = 0; m_init = 0; m_strt = 0; m_stop = 1; m_poll = 0;
      m_rxon = 0; m_txon = 0; m_inea = 0; m_ok = 0; m_lo = 0; m_hi = 0; m_bus = 0;
    end else begin
      t_w0 = host_we && !host_port && (m_sel == 2'd0);
      if (host_we && !host_port && m_stop) begin
        if (m_sel == 2'd1) m_lo = host_wdata;
        if (m_sel == 2'd2) m_hi = host_wdata[7:0];
        if (m_sel == 2'd3) m_bus = host_wdata[2:0];
      end
      if (t_w0 && host_wdata[2]) begin
        m_fl = 0; m_init = 0; m_strt = 0; m_stop = 1; m_poll = 0;
        m_rxon = 0; m_txon = 0; m_inea = 0; m_ok = 0;
      end else begin
        t_fin = ev[0] && m_init;
        if (t_w0) m_fl = m_fl & ~host_wdata[14:8];
        if (!m_stop) m_fl = m_fl | {ev[6:1], t_fin};
        if (t_w0 && host_wdata[0]) m_init = 1;
        else if (t_fin) m_init = 0;
        if (t_fin) m_ok = 1;
        if (t_w0 && host_wdata[1]) m_strt = 1;
        if (t_w0 && (host_wdata[0] || host_wdata[1])) m_stop = 0;
        if (t_w0) m_inea = host_wdata[6];
        m_poll = t_w0 && host_wdata[3] && !m_stop;
        t_go = m_strt && m_ok;
        if (t_go) begin m_rxon = 1; m_txon = 1; end
      end
      if (host_we && host_port) m_sel = host_wdata[1:0];
    end
  end

  function automatic logic m_intr();
    return m_fl[6] | m_fl[4] | m_fl[3] | m_fl[2] | m_fl[1] | m_fl[0];
  endfunction

  function automatic logic [15:0] exp_rd();
    if (host_port) return {14'b0, m_sel};
    case (m_sel)
      2'd0: return {(|m_fl[6:3]), m_fl, m_intr(), m_inea, m_rxon, m_txon, m_poll, m_stop, m_strt, m_init};
      2'd1: return m_lo;
      2'd2: return {8'b0, m_hi};
      default: return {13'b0, m_bus};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #(CLK_P/4);
    if (rst_n && !done) begin
      chk("R3 rdata vs model", host_rdata, exp_rd());
      chk("R7 irq_n vs model", irq_n, !(m_intr() && m_inea));
      chk("R10 rx/tx enables vs model", {rx_on, tx_on}, {m_rxon, m_txon});
      chk("R11 tx_poll vs model", tx_poll, m_poll);
      chk("R9 init_req vs model", init_req, m_init);
      chk("R12 config outputs vs model", {init_addr, bus_cfg}, {m_hi, m_lo, m_bus});
    end
  end

  task automatic wr_data(input logic [15:0] v);
    @(negedge clk); host_we = 1; host_port = 0; host_wdata = v;
    @(negedge clk); host_we = 0; #1;
  endtask

  task automatic wr_sel(input logic [1:0] n);
    @(negedge clk); host_we = 1; host_port = 1; host_wdata = {14'b0, n};
    @(negedge clk); host_we = 0; host_port = 0; #1;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk); ev = m;
    @(negedge clk); ev = 0; #1;
  endtask

  localparam logic [6:0] E_BABL = 7'h40, E_CERR = 7'h20, E_MISS = 7'h10,
                         E_MERR = 7'h08, E_RINT = 7'h04, E_DONE = 7'h01;

  initial begin
    #(CLK_P*50000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; host_we = 0; host_port = 0; host_wdata = 0; ev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    chk("R2 reset run reg", host_rdata, 16'h0004);
    chk("R2 reset irq_n", irq_n, 1'b1);
    chk("R2 reset outputs", {init_req, rx_on, tx_on, tx_poll, init_addr, bus_cfg}, 0);

    wr_sel(2'd2);
    host_port = 1; #1;
    chk("R1 address port readback", host_rdata, 16'h0002);
    host_port = 0; #1;
    chk("R2 reset pointer high", host_rdata, 16'h0000);

    wr_sel(2'd1); wr_data(16'h1234);
    wr_sel(2'd2); wr_data(16'hFFAB);
    chk("R12 high pointer upper bits zero", host_rdata, 16'h00AB);
    wr_sel(2'd3); wr_data(16'hFFFF);
    chk("R12 bus config readback", host_rdata, 16'h0007);
    chk("R12 init_addr", init_addr, 24'hAB1234);

    wr_sel(2'd0); wr_data(16'h0001);
    chk("R9 init clears stop", host_rdata, 16'h0001);
    chk("R9 init_req", init_req, 1'b1);

    wr_sel(2'd1); wr_data(16'h0000); wr_sel(2'd0);
    chk("R12 write ignored while running", init_addr, 24'hAB1234);

    pulse(E_DONE);
    chk("R9 init done flag", host_rdata, 16'h0180);
    chk("R7 no irq without enable", irq_n, 1'b1);

    wr_data(16'h0040);
    chk("R13 enable loaded, R5 zero write keeps flag", host_rdata, 16'h01C0);
    chk("R7 irq asserted", irq_n, 1'b0);

    wr_data(16'h0140);
    chk("R5 write one clears", host_rdata, 16'h0040);
    chk("R7 irq released", irq_n, 1'b1);

    wr_data(16'h0042);
    chk("R10 start after init", {rx_on, tx_on, host_rdata}, {2'b11, 16'h0072});

    wr_data(16'h0048);
    chk("R11 poll raised", {tx_poll, host_rdata}, {1'b1, 16'h007A});
    @(negedge clk); #1;
    chk("R11 poll self clears", {tx_poll, host_rdata}, {1'b0, 16'h0072});

    pulse(E_CERR);
    chk("R4 error summary", host_rdata, 16'hA072);
    chk("R7 heartbeat error not an interrupt", irq_n, 1'b1);

    wr_data(16'h8040);
    chk("R4 bit 15 not writable", host_rdata, 16'hA072);

    @(negedge clk); host_we = 1; host_wdata = 16'h0440; ev = E_RINT;
    @(negedge clk); host_we = 0; ev = 0; #1;
    chk("R5 event beats clear", host_rdata, 16'hA4F2);
    chk("R7 receive interrupt", irq_n, 1'b0);

    wr_data(16'h2440);
    chk("R5 clear two flags", host_rdata, 16'h0072);

    pulse(E_BABL | E_MISS | E_MERR);
    chk("R4 error flags", host_rdata, 16'hD8F2);

    wr_data(16'h0004);
    chk("R8 stop", {rx_on, tx_on, irq_n, host_rdata}, {2'b00, 1'b1, 16'h0004});
    chk("R8 config kept", {init_addr, bus_cfg}, {24'hAB1234, 3'd7});

    pulse(7'h7F);
    chk("R6 events ignored while stopped", host_rdata, 16'h0004);

    wr_data(16'h0008);
    chk("R11 poll dropped while stopped", {tx_poll, host_rdata}, {1'b0, 16'h0004});

    wr_data(16'h0002);
    chk("R10 start alone keeps links off", {rx_on, host_rdata}, {1'b0, 16'h0002});
    wr_data(16'h0003);
    chk("R10 still waiting for init", {rx_on, host_rdata}, {1'b0, 16'h0003});
    pulse(E_DONE);
    chk("R10 on after late init", {rx_on, tx_on, host_rdata}, {2'b11, 16'h01B2});

    // random phase, compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      host_we    = ($urandom % 3) == 0;
      host_port  = ($urandom % 6) == 0;
      host_wdata = 16'($urandom);
      if (($urandom % 24) != 0) host_wdata[2] = 1'b0;
      ev         = 7'($urandom & $urandom);
    end
    @(negedge clk); host_we = 0; host_port = 0; ev = 0;
    repeat (3) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule